// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one output compare channel that sits beside an 8-bit timer/counter. On every timer tick it compares the running count with an active compare value. When the two are equal it raises a sticky match flag and updates an internal waveform bit. A 2-bit action field decides whether that update sets, clears or toggles the bit. The counter itself, its prescaler, its top/bottom sequencing, pin muxing and interrupt routing all live outside this block. The block only consumes the tick, the count and the top/bottom indicators.

When the surrounding timer runs a PWM waveform, software writes to the compare value land in a shadow buffer. The buffer is copied into the active register at the top or at the bottom of the count, whichever the timer selects. In the other modes the write reaches the active register at once. Three further controls act on the match logic:
- A force strobe applies the configured action to the waveform bit without a real match, and only outside PWM operation.
- A software write to the counter hides any match for one tick, so that loading the counter equal to the compare value raises nothing.
- The action field is unbuffered and takes effect on the very next event.

Top module: `ocu_channel`

## Requirements
- R1: After reset the compare readback is 0, the match flag is 0, the waveform bit is 0 and the output enable is 0 when the action field is 00.
- R2: With `pwm_mode` low, a write on `cmp_wr` stores `cmp_wdata` in the active compare register, visible on `cmp_rdata` in the next cycle and used by the very next tick.
- R3: With `pwm_mode` high, a write on `cmp_wr` stores only the shadow buffer. `cmp_rdata` shows the buffer, and matching keeps using the previous active value until a transfer.
- R4: With `pwm_mode` high, the buffer moves to the active register on a tick with `at_top` high when `load_at_top` is 1, or on a tick with `at_bottom` high when `load_at_top` is 0. A tick at the other end performs no transfer.
- R5: A tick whose `count` equals the active compare value, and which is not blocked, sets `match_flag` from the next cycle on. `match_flag` stays set until `flag_clr` is pulsed. A match in the same cycle as `flag_clr` leaves the flag set.
- R6: On a match, the waveform bit follows `com_mode`: 00 leaves it unchanged, 01 toggles it, 10 clears it, 11 sets it. The new value appears in the next cycle, and the bit does not change without a match or an accepted force.
- R7: With `pwm_mode` low, `force_cmp` updates the waveform bit by the same `com_mode` rule as a match but never sets `match_flag`. With `pwm_mode` high, `force_cmp` has no effect.
- R8: A `cnt_wr` pulse suppresses matches in its own cycle and on the first tick that follows it, even if that tick comes many cycles later. The tick after that one matches normally.
- R9: `out_en` is high exactly when `com_mode` is nonzero, in the same cycle. A `com_mode` change applies to the next match with no buffering.
- R10: The waveform bit keeps its value when `pwm_mode` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer clock enable; one compare per tick |
| count | input | 8 | Current timer count |
| at_top | input | 1 | Count is at the top of its sequence |
| at_bottom | input | 1 | Count is at the bottom of its sequence |
| pwm_mode | input | 1 | Timer is in a PWM mode (buffering on, force off) |
| load_at_top | input | 1 | In PWM, transfer buffer at top (1) or bottom (0) |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | 8 | Compare value write data |
| cnt_wr | input | 1 | Software wrote the counter this cycle |
| force_cmp | input | 1 | Force-compare strobe |
| com_mode | input | 2 | Match action: 00 none, 01 toggle, 10 clear, 11 set |
| flag_clr | input | 1 | Clears the match flag |
| cmp_rdata | output | 8 | Compare readback (buffer in PWM, active otherwise) |
| match_flag | output | 1 | Sticky match flag |
| wave_out | output | 1 | Internal waveform bit |
| out_en | output | 1 | Waveform drives the pin |

## Verification
A wrong active compare value shows up one cycle after the next tick. The flag either fails to rise at the matching count or rises at a different count, and a full count sweep exposes any such value. Three kinds of internal fault are all visible in a single cycle:
- A stale or early buffer transfer moves the match point to the wrong count, immediately after the top or bottom tick.
- A sticky block left behind after a counter write loses a real match on the second tick.
- A wrong action decode leaves the waveform bit at a value that differs from the expected one in the cycle after the event.

// File: rtl/ocu_channel.sv
module ocu_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic         at_top,
  input  logic         at_bottom,
  input  logic         pwm_mode,
  input  logic         load_at_top,
  input  logic         cmp_wr,
  input  logic [W-1:0] cmp_wdata,
  input  logic         cnt_wr,
  input  logic         force_cmp,
  input  logic [1:0]   com_mode,
  input  logic         flag_clr,
  output logic [W-1:0] cmp_rdata,
  output logic         match_flag,
  output logic         wave_out,
  output logic         out_en
);

  logic [W-1:0] ocr_act, ocr_buf;
  logic         blk;
  logic         hit, frc, load_pt, act_ev;
  logic         wave_nx;

  assign load_pt = tick & (load_at_top ? at_top : at_bottom);
  assign hit     = tick & (count == ocr_act) & ~blk & ~cnt_wr;
  assign frc     = force_cmp & ~pwm_mode;
  assign act_ev  = hit | frc;

  always_comb begin
    unique case (com_mode)
      2'b01:   wave_nx = ~wave_out;
      2'b10:   wave_nx = 1'b0;
      2'b11:   wave_nx = 1'b1;
      default: wave_nx = wave_out;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocr_buf <= '0;
      ocr_act <= '0;
    end else begin
      if (cmp_wr) ocr_buf <= cmp_wdata;
      if (cmp_wr && !pwm_mode) ocr_act <= cmp_wdata;
      else if (pwm_mode && load_pt) ocr_act <= ocr_buf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blk <= 1'b0;
    else if (cnt_wr) blk <= 1'b1;
    else if (tick)   blk <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_flag <= 1'b0;
      wave_out   <= 1'b0;
    end else begin
      if (hit)           match_flag <= 1'b1;
      else if (flag_clr) match_flag <= 1'b0;
      if (act_ev) wave_out <= wave_nx;
    end
  end

  assign cmp_rdata = pwm_mode ? ocr_buf : ocr_act;
  assign out_en    = |com_mode;

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_flag && !flag_clr |=> match_flag);

  // R7
  force_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_cmp && !hit && !match_flag |=> !match_flag);

  // R8
  cnt_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr && !match_flag |=> !match_flag);

  // R3
  pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_mode && !load_pt |=> $stable(ocr_act));

  // R6
  wave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit && !frc |=> $stable(wave_out));

endmodule

// File: tb/tb_ocu_channel.sv
module tb_ocu_channel;
  logic clk = 0, rst_n = 0;
  logic tick = 0, at_top = 0, at_bottom = 0, pwm_mode = 0, load_at_top = 1;
  logic cmp_wr = 0, cnt_wr = 0, force_cmp = 0, flag_clr = 0;
  logic [7:0] count = 0, cmp_wdata = 0;
  logic [1:0] com_mode = 0;
  logic [7:0] cmp_rdata;
  logic match_flag, wave_out, out_en;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ocu_channel dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_cmp(input logic [7:0] v);
    cmp_wr = 1; cmp_wdata = v; step(); cmp_wr = 0;
  endtask

  task automatic do_tick(input logic [7:0] c, input logic top, input logic bot);
    count = c; at_top = top; at_bottom = bot; tick = 1; step();
    tick = 0; at_top = 0; at_bottom = 0;
  endtask

  task automatic clr_flag();
    flag_clr = 1; step(); flag_clr = 0;
  endtask

  task automatic force_wave(input logic v);
    logic pm;
    pm = pwm_mode; pwm_mode = 0;
    com_mode = v ? 2'b11 : 2'b10; force_cmp = 1; step(); force_cmp = 0;
    pwm_mode = pm;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    repeat (3) step();
    rst_n = 1; step();
    // R1 reset state
    chk("R1 rdata", cmp_rdata, 0);
    chk("R1 flag", match_flag, 0);
    chk("R1 wave", wave_out, 0);
    chk("R1 oe", out_en, 0);

    // R2 direct write, full sweep of count
    wr_cmp(8'h5A);
    chk("R2 rdata", cmp_rdata, 8'h5A);
    for (int c = 0; c < 256; c++) begin
      do_tick(c[7:0], 0, 0);
      chk("R2 sweep match", match_flag, (c == 8'h5A) ? 1 : 0);
      clr_flag();
    end

    // R5 flag sticky, set wins over clear
    do_tick(8'h5A, 0, 0);
    repeat (4) step();
    chk("R5 sticky", match_flag, 1);
    clr_flag();
    chk("R5 cleared", match_flag, 0);
    flag_clr = 1; do_tick(8'h5A, 0, 0); flag_clr = 0;
    chk("R5 set wins", match_flag, 1);
    clr_flag();

    // R6 / R9 action sweep from both initial levels
    for (int init = 0; init < 2; init++) begin
      for (int m = 0; m < 4; m++) begin
        int exp;
        force_wave(init[0]);
        com_mode = m[1:0];
        #1;
        chk("R9 oe", out_en, (m != 0) ? 1 : 0);
        do_tick(8'h5A, 0, 0);
        exp = (m == 0) ? init : (m == 1) ? 1 - init : (m == 2) ? 0 : 1;
        chk("R6 action", wave_out, exp);
        clr_flag();
      end
    end

    // R6 no change without match
    force_wave(1); com_mode = 2'b01;
    do_tick(8'h11, 0, 0);
    chk("R6 no match no change", wave_out, 1);

    // R7 force in non-PWM: wave toggles, flag untouched
    com_mode = 2'b01; force_cmp = 1; step(); force_cmp = 0;
    chk("R7 force wave", wave_out, 0);
    chk("R7 force no flag", match_flag, 0);
    pwm_mode = 1; force_cmp = 1; step(); force_cmp = 0;
    chk("R7 force ignored pwm", wave_out, 0);
    chk("R7 no flag pwm", match_flag, 0);

    // R10 wave held over mode change
    force_wave(1);
    pwm_mode = 1; step(); pwm_mode = 0; step();
    chk("R10 wave kept", wave_out, 1);

    // R3 / R4 buffering, load at top
    com_mode = 2'b00;
    pwm_mode = 1; load_at_top = 1;
    wr_cmp(8'h20);
    chk("R3 rdata buffer", cmp_rdata, 8'h20);
    do_tick(8'h5A, 0, 0);
    chk("R3 old active used", match_flag, 1);
    clr_flag();
    do_tick(8'h20, 0, 1);
    chk("R4 no load at bottom", match_flag, 0);
    do_tick(8'hFF, 1, 0);
    chk("R4 top tick no match", match_flag, 0);
    do_tick(8'h20, 0, 0);
    chk("R4 loaded at top", match_flag, 1);
    clr_flag();

    // R4 load at bottom
    load_at_top = 0;
    wr_cmp(8'h30);
    do_tick(8'hFF, 1, 0);
    do_tick(8'h30, 0, 0);
    chk("R4 no load at top", match_flag, 0);
    do_tick(8'h00, 0, 1);
    do_tick(8'h30, 0, 0);
    chk("R4 loaded at bottom", match_flag, 1);
    clr_flag();
    pwm_mode = 0;
    #1;
    chk("R2 rdata active", cmp_rdata, 8'h30);

    // R8 counter write blocks next tick, even when stopped
    wr_cmp(8'h40);
    count = 8'h40; cnt_wr = 1; step(); cnt_wr = 0;
    chk("R8 same cycle", match_flag, 0);
    repeat (5) step();
    do_tick(8'h40, 0, 0);
    chk("R8 first tick blocked", match_flag, 0);
    do_tick(8'h40, 0, 0);
    chk("R8 second tick matches", match_flag, 1);
    clr_flag();
    cnt_wr = 1; do_tick(8'h40, 0, 0); cnt_wr = 0;
    chk("R8 write with tick", match_flag, 0);
    do_tick(8'h40, 0, 0);
    chk("R8 following tick blocked", match_flag, 0);
    do_tick(8'h40, 0, 0);
    chk("R8 recovered", match_flag, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule